// File: doc/BRIEF.md
# Successive approximation register controller

This block holds the trial word and runs the bit-by-bit search of a successive approximation analog-to-digital converter. A conversion begins with the most significant result bit set on its own. On each later rising clock edge the bit under trial is kept or cleared, according to the comparator input, and the next lower bit is set for its own trial. The parallel result drives an external DAC, and the comparator judges the analog input against that DAC level. A one-bit serial stream repeats each decision during the clock period after the decision is made. An end-of-conversion flag is raised on a falling clock edge, so the result bits have half a period to settle before the flag appears.

A parameter chooses what the auxiliary control input does. In the master-reset variant, that input clears the block on a rising edge, and the clear persists until the start input is seen high. This lets several blocks be chained into longer words. In the feed-forward variant, the auxiliary input ends the conversion early. Wiring it to the result bit just below the last wanted bit gives a shorter word. In this variant the block also restarts by itself when start and end-of-conversion are both high. Either variant can free-run, with start tied to end-of-conversion, or can be strobed by an external start.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst` is high on a rising edge, `result_o` and `ser_o` are 0, and `eoc_o` is 0 from the following falling edge.
- R2: A rising edge on which `start_i` is 1 and was 0 at the previous rising edge launches a conversion: `result_o` becomes only its top bit set (0x80 for 8 bits).
- R3: On each of the next WIDTH rising edges the bit under trial is kept when `cmp_i` is 1 and cleared when it is 0, and the next lower bit is set to 1. Bits already decided keep their values. With an ideal comparator (`cmp_i` = analog code >= `result_o`), `result_o` equals the analog code after WIDTH edges.
- R4: `eoc_o` rises on the falling edge that follows the edge deciding bit 0. It stays high until a launch, and falls on the falling edge after that launch.
- R5: After each deciding edge, `ser_o` carries the bit just decided, most significant first, for one period. `ser_o` is 0 in the period after a launch and in the period after the edge that follows the last decision.
- R6: In the master-reset variant, `start_i` held at 1 or held at 0 without a new rising edge does not relaunch. A finished result and `eoc_o` are kept.
- R7: With `start_i` tied to `eoc_o`, the block relaunches on the rising edge after `eoc_o` rises, giving one result every WIDTH+1 cycles.
- R8: In the master-reset variant, a rising edge with `mode_ctl_i` = 1 clears `result_o` and `ser_o` and stops the conversion. `eoc_o` is 0 from the next falling edge.
- R9: In the master-reset variant, after `mode_ctl_i` returns to 0 the block stays cleared while `start_i` is 0. It launches on the first edge with `start_i` = 1, even if `start_i` was already 1 while the clear was applied.
- R10: In the feed-forward variant, `mode_ctl_i` = 1 during a conversion raises `eoc_o` on the next falling edge. With `mode_ctl_i` tied to `result_o[1]`, `eoc_o` rises after 6 deciding edges with `result_o[7:2]` equal to the code, and `ser_o` is 0 in the period after the next edge.
- R11: In the feed-forward variant, `start_i` = 1 while `eoc_o` = 1 launches even if `start_i` was already 1, so the block recirculates with `start_i` held high.
- R12: In the feed-forward variant, a block that is neither converting nor holding a finished result launches by itself on the next edge. A full conversion then ends with `eoc_o` = 1 and the code in `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge, `eoc_o` updated on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-convert strobe |
| cmp_i | input | 1 | Comparator decision for the bit under trial (1 = keep) |
| mode_ctl_i | input | 1 | Master reset or feed-forward, chosen by `VARIANT` |
| result_o | output | WIDTH | Parallel trial/result word |
| eoc_o | output | 1 | End-of-conversion flag |
| ser_o | output | 1 | Serial stream of decided bits |

## Verification
The assertions assume that `start_i`, `cmp_i` and `mode_ctl_i` are synchronous to `clk` and change only between edges. They also assume that the comparator answer depends only on the present `result_o`. The feed-forward assertions further assume that `mode_ctl_i` comes from a result bit or a constant. The bench respects these assumptions. It updates stimulus at one fixed point of the low clock phase, well after the falling edge. Its comparator is a combinational comparison of a held analog code with `result_o`. In the feed-forward variant, `mode_ctl_i` is either 0 or `result_o[1]`.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Meaning of the auxiliary control input
    typedef enum logic {
        VAR_MASTER_RESET = 1'b0,
        VAR_FEED_FORWARD = 1'b1
    } sar_variant_e;

    // Per-edge control decisions handed from the launch logic to the datapath
    typedef struct packed {
        logic launch;   // load the top trial bit
        logic clear;    // master reset, highest priority after rst
        logic step;     // decide the bit under trial
        logic ff_hit;   // feed-forward marks the conversion finished
    } sar_ctrl_t;

    function automatic logic [31:0] top_bit_word(input int unsigned width);
        logic [31:0] w;
        w = '0;
        w[width-1] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sar_launch.sv
module sar_launch
    import sar_pkg::*;
#(
    parameter sar_variant_e VARIANT = VAR_MASTER_RESET
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      aux_i,
    input  logic      eoc_i,
    input  logic      busy_i,
    input  logic      done_i,
    output sar_ctrl_t ctrl_o
);

    logic start_prev;
    logic mr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_prev <= 1'b0;
            mr_prev    <= 1'b0;
        end else begin
            start_prev <= start_i;
            mr_prev    <= aux_i;
        end
    end

    always_comb begin
        ctrl_o.step = busy_i;
        if (VARIANT == VAR_MASTER_RESET) begin
            ctrl_o.clear  = aux_i;
            ctrl_o.ff_hit = 1'b0;
            ctrl_o.launch = !aux_i && start_i && (!start_prev || mr_prev);
        end else begin
            ctrl_o.clear  = 1'b0;
            ctrl_o.ff_hit = aux_i && busy_i;
            // idle without a result is not a resting state
            ctrl_o.launch = (start_i && (!start_prev || eoc_i))
                          || (!busy_i && !done_i);
        end
    end

    AST_NO_LAUNCH_DURING_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctrl_o.clear |-> !ctrl_o.launch); // R8

endmodule

// File: rtl/sar_trial.sv
module sar_trial
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sar_ctrl_t        ctrl_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] result_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [31:0]      TOP_W   = top_bit_word(WIDTH);
    localparam logic [WIDTH-1:0] TOP_BIT = TOP_W[WIDTH-1:0];

    logic [WIDTH-1:0] probe;   // one-hot marker of the bit under trial
    logic [WIDTH-1:0] res;
    logic             done;

    always_ff @(posedge clk) begin
        if (rst || ctrl_i.clear) begin
            res   <= '0;
            probe <= '0;
            done  <= 1'b0;
        end else if (ctrl_i.launch) begin
            res   <= TOP_BIT;
            probe <= TOP_BIT;
            done  <= 1'b0;
        end else if (ctrl_i.step) begin
            res   <= (res & ~probe) | (cmp_i ? probe : '0) | (probe >> 1);
            probe <= probe >> 1;
            done  <= done | probe[0] | ctrl_i.ff_hit;
        end
    end

    assign result_o = res;
    assign busy_o   = |probe;
    assign done_o   = done;

    AST_TRIAL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(probe)); // R3

    AST_LAUNCH_LOADS_TOP: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.launch && !ctrl_i.clear |=> result_o == TOP_BIT); // R2

    AST_DECIDED_BITS_STABLE: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.step && !ctrl_i.clear && !ctrl_i.launch
        |=> ((result_o ^ $past(result_o)) & ~($past(probe) | ($past(probe) >> 1))) == '0); // R3

endmodule

// File: rtl/sar_flags.sv
module sar_flags
    import sar_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sar_ctrl_t ctrl_i,
    input  logic      cmp_i,
    input  logic      busy_i,
    input  logic      done_i,
    output logic      eoc_o,
    output logic      ser_o
);

    logic eoc_q;
    logic ser_q;

    // falling-edge flag: gives the result half a period to settle
    always_ff @(negedge clk) begin
        if (rst) eoc_q <= 1'b0;
        else     eoc_q <= done_i | ctrl_i.ff_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_i.clear || ctrl_i.launch)
            ser_q <= 1'b0;
        else if (busy_i && !done_i && !ctrl_i.ff_hit)
            ser_q <= cmp_i;
        else
            ser_q <= 1'b0;
    end

    assign eoc_o = eoc_q;
    assign ser_o = ser_q;

    AST_SER_QUIET_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.launch |=> !ser_o); // R5

    AST_EOC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        eoc_o && !ctrl_i.launch && !ctrl_i.clear |=> eoc_o); // R4

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned  WIDTH   = 8,
    parameter sar_variant_e VARIANT = VAR_MASTER_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic             mode_ctl_i,
    output logic [WIDTH-1:0] result_o,
    output logic             eoc_o,
    output logic             ser_o
);

    sar_ctrl_t ctrl;
    logic      busy;
    logic      done;

    sar_launch #(.VARIANT(VARIANT)) u_launch (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .aux_i   (mode_ctl_i),
        .eoc_i   (eoc_o),
        .busy_i  (busy),
        .done_i  (done),
        .ctrl_o  (ctrl)
    );

    sar_trial #(.WIDTH(WIDTH)) u_trial (
        .clk      (clk),
        .rst      (rst),
        .ctrl_i   (ctrl),
        .cmp_i    (cmp_i),
        .result_o (result_o),
        .busy_o   (busy),
        .done_o   (done)
    );

    sar_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl),
        .cmp_i  (cmp_i),
        .busy_i (busy),
        .done_i (done),
        .eoc_o  (eoc_o),
        .ser_o  (ser_o)
    );

    if (VARIANT == VAR_MASTER_RESET) begin : g_mr_checks
        AST_MASTER_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
            mode_ctl_i |=> result_o == '0 && !busy && !ser_o); // R8
    end else begin : g_ff_checks
        AST_FF_NO_STALL: assert property (@(posedge clk) disable iff (rst)
            !busy && !done |=> busy); // R12
    end

endmodule

// File: tb/test_sar_ctrl.sv
`timescale 1ns/1ps
module test_sar_ctrl;
    import sar_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // master-reset instance
    logic       a_start = 1'b0, a_aux = 1'b0, a_free = 1'b0;
    logic [7:0] a_code  = 8'h00;
    logic [7:0] a_q;
    logic       a_eoc, a_ser;
    wire        a_start_w = a_free ? a_eoc : a_start;
    wire        a_cmp     = (a_code >= a_q);

    // feed-forward instance
    logic       b_start = 1'b0, b_ff6 = 1'b0;
    logic [7:0] b_code  = 8'hA5;
    logic [7:0] b_q;
    logic       b_eoc, b_ser;
    wire        b_aux_w = b_ff6 ? b_q[1] : 1'b0;
    wire        b_cmp   = (b_code >= b_q);

    sar_ctrl #(.WIDTH(8), .VARIANT(VAR_MASTER_RESET)) i_sar_ctrl (
        .clk(clk), .rst(rst), .start_i(a_start_w), .cmp_i(a_cmp),
        .mode_ctl_i(a_aux), .result_o(a_q), .eoc_o(a_eoc), .ser_o(a_ser));

    sar_ctrl #(.WIDTH(8), .VARIANT(VAR_FEED_FORWARD)) i_sar_ctrl_ff (
        .clk(clk), .rst(rst), .start_i(b_start), .cmp_i(b_cmp),
        .mode_ctl_i(b_aux_w), .result_o(b_q), .eoc_o(b_eoc), .ser_o(b_ser));

    // {hold start high, analog code}
    localparam logic [8:0] VEC [8] = '{9'h000, 9'h1FF, 9'h080, 9'h17F,
                                       9'h001, 9'h1A5, 9'h03C, 9'h1D2};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one rising edge, then land after the falling edge
    task automatic step();
        @(posedge clk);
        #4;
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        step(); step(); step();
        chk("R1 result", a_q, 8'h00);
        chk("R1 eoc", a_eoc, 1'b0);
        chk("R1 ser", a_ser, 1'b0);
        chk("R1 ff result", b_q, 8'h00);
        chk("R1 ff eoc", b_eoc, 1'b0);
        rst = 1'b0;

        // R12 feed-forward self launch with start low
        step();
        chk("R12 self launch", b_q, 8'h80);
        for (int k = 0; k < 8; k++) step();
        chk("R12 result", b_q, 8'hA5);
        chk("R12 eoc", b_eoc, 1'b1);
        chk("R6 idle start low keeps cleared", a_q, 8'h00);

        // table: strobed conversions on the master-reset instance
        for (int i = 0; i < 8; i++) begin
            a_code  = VEC[i][7:0];
            a_start = 1'b1;
            step();
            chk("R2 launch top bit", a_q, 8'h80);
            chk("R5 ser quiet after launch", a_ser, 1'b0);
            chk("R4 eoc low after launch", a_eoc, 1'b0);
            a_start = VEC[i][8];
            for (int k = 1; k <= 8; k++) begin
                step();
                chk("R5 serial bit", a_ser, a_code[8-k]);
                chk("R4 eoc timing", a_eoc, (k == 8));
                chk("R3 decided bits", a_q >> (8-k), a_code >> (8-k));
            end
            chk("R3 final result", a_q, a_code);
            step();
            chk("R5 ser quiet after end", a_ser, 1'b0);
            chk("R6 no relaunch result", a_q, a_code);
            chk("R6 no relaunch eoc", a_eoc, 1'b1);
            a_start = 1'b0;
            step();
        end

        // R7 free run
        a_code = 8'h5A;
        a_free = 1'b1;
        step();
        chk("R7 first launch", a_q, 8'h80);
        for (int k = 0; k < 8; k++) step();
        chk("R7 first result", a_q, 8'h5A);
        chk("R7 first eoc", a_eoc, 1'b1);
        a_code = 8'hC3;
        step();
        chk("R7 relaunch", a_q, 8'h80);
        chk("R7 eoc dropped", a_eoc, 1'b0);
        for (int k = 0; k < 8; k++) step();
        chk("R7 second result", a_q, 8'hC3);
        chk("R7 second eoc", a_eoc, 1'b1);
        a_free = 1'b0;
        a_start = 1'b0;
        step();

        // R8 / R9 master reset
        a_code = 8'h6B;
        a_start = 1'b1;
        step();
        a_start = 1'b0;
        for (int k = 0; k < 8; k++) step();
        chk("R3 before clear", a_q, 8'h6B);
        a_aux = 1'b1;
        step();
        chk("R8 clear result", a_q, 8'h00);
        chk("R8 clear eoc", a_eoc, 1'b0);
        chk("R8 clear ser", a_ser, 1'b0);
        a_aux = 1'b0;
        step(); step(); step();
        chk("R9 stays cleared", a_q, 8'h00);
        chk("R9 eoc low", a_eoc, 1'b0);
        a_start = 1'b1;
        step();
        chk("R9 launch after release", a_q, 8'h80);
        step(); step();
        a_aux = 1'b1;
        step();
        chk("R8 clear mid conversion", a_q, 8'h00);
        chk("R8 ser mid conversion", a_ser, 1'b0);
        a_aux = 1'b0;
        step();
        chk("R9 launch with start held", a_q, 8'h80);
        for (int k = 0; k < 8; k++) step();
        chk("R9 result", a_q, 8'h6B);
        a_start = 1'b0;

        // R10 feed-forward 6-bit shortening
        b_code = 8'hB7;
        b_ff6  = 1'b1;
        b_start = 1'b1;
        step();
        chk("R10 launch", b_q, 8'h80);
        b_start = 1'b0;
        for (int k = 1; k <= 5; k++) step();
        chk("R10 eoc not yet", b_eoc, 1'b0);
        step();
        chk("R10 eoc after 6", b_eoc, 1'b1);
        chk("R10 upper bits", b_q[7:2], b_code[7:2]);
        chk("R10 last serial bit", b_ser, b_code[2]);
        step();
        chk("R10 ser quiet", b_ser, 1'b0);
        chk("R10 eoc held", b_eoc, 1'b1);
        step(); step();
        chk("R10 eoc still held", b_eoc, 1'b1);
        b_ff6 = 1'b0;

        // R11 recirculation with start held high
        b_code = 8'h3E;
        b_start = 1'b1;
        step();
        chk("R11 launch", b_q, 8'h80);
        for (int k = 0; k < 8; k++) step();
        chk("R11 first result", b_q, 8'h3E);
        b_code = 8'h91;
        step();
        chk("R11 recirculate", b_q, 8'h80);
        for (int k = 0; k < 8; k++) step();
        chk("R11 second result", b_q, 8'h91);
        chk("R11 eoc", b_eoc, 1'b1);
        b_start = 1'b0;
        step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule